// File: doc/BRIEF.md
# Shared Receive Queue with Interrupt Hold-Off

This block gathers received characters from up to eight serial lines into one shared first-in first-out queue. It then tells the host when to service that queue. The line receivers offer each character on a write port, together with its line number and three error flags. The host pops one 16-bit word per read. Each word carries a valid flag, the error flags, the line number and the data byte. A not-empty status stays high until the queue has been drained.

An interrupt request is raised only when the host enable input is high. A programmable 8-bit hold-off value picks one of three policies:

- **Value 0:** wait until the queue is three-quarters full.
- **Value 1:** request as soon as anything is queued.
- **Value N from 2 to 255:** wait N millisecond ticks after a triggering event.

A triggering event is either of these, provided the enable is high:

- a character lands in an empty queue;
- the enable rises while data is already queued.

Later characters do not restart a countdown that is already running. A new countdown can only begin after the queue has emptied. The host supplies the millisecond tick as a one-cycle pulse.

Top module: `rxq_holdoff`

## Requirements
- R1: A read of a non-empty queue returns, in arrival order, a word laid out as follows: bit 15 = 1 (valid), bit 14 overrun, bit 13 framing error, bit 12 parity error, bits 11:8 line number, bits 7:0 data. The word is visible on `rd_word` in the cycle after the clock edge that sampled `rd_en`, and it holds until the next read.
- R2: A read while the queue is empty returns 16'h0000, so the valid bit is clear.
- R3: `not_empty` is high whenever at least one entry is stored. It falls only on a clock edge that sampled `rd_en` and removed the last entry.
- R4: The queue holds 64 entries. If a character arrives while the queue is full and no read happens in the same cycle, it replaces the newest stored entry, with bit 14 (overrun) forced to 1. The occupancy stays at 64, and the older 63 entries are untouched.
- R5: Synchronous reset empties the queue, clears `irq` and `rd_word`, and loads the hold-off value with 1. It does not depend on or alter `rie`.
- R6: With hold-off value 1, `irq` goes high on the same edge that makes the queue non-empty, provided `rie` is high at that edge.
- R7: With hold-off value 0, `irq` is high only while the queue holds at least 48 entries and `rie` is high.
- R8: With hold-off value N ≥ 2, `irq` rises on the edge of the Nth `tick_ms` pulse after a triggering event. A tick sampled in the same cycle as the event is not counted. `irq` then stays high until the queue empties or `rie` falls.
- R9: Further characters that arrive during a running countdown do not restart it. After the queue drains, the next character into the empty queue starts a fresh countdown of N ticks.
- R10: A rise of `rie` while the queue already holds data counts as a triggering event.
- R11: `irq` is low in every cycle after an edge at which `rie` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receiver offers a character this cycle |
| wr_line | input | 4 | Line number of the offered character |
| wr_data | input | 8 | Character data |
| wr_ovr | input | 1 | Receiver-side overrun flag |
| wr_frm | input | 1 | Framing error flag |
| wr_par | input | 1 | Parity error flag |
| rd_en | input | 1 | Host pops one word |
| rd_word | output | 16 | Popped word (layout in R1) |
| rie | input | 1 | Receive interrupt enable |
| tim_we | input | 1 | Load a new hold-off value |
| tim_val | input | 8 | Hold-off value to load |
| tick_ms | input | 1 | One-cycle millisecond tick |
| irq | output | 1 | Registered interrupt request |
| not_empty | output | 1 | Registered queue-non-empty status |

## Verification
The hold-off assertions assume that the hold-off value is rewritten only while the queue is empty. A change of policy while data waits would leave the countdown state describing a policy no longer in force. The bench therefore loads every new hold-off value between drains.

The assertions also assume that `tick_ms` is a single-cycle pulse. The bench generates ticks on separate cycles, and never in the same cycle as the character or enable edge that starts a countdown. This keeps the tick count at which `irq` rises unambiguous.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LINE_W = 4;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              ovr;
    logic              frm;
    logic              par;
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  localparam int ENTRY_W = $bits(rxq_entry_t);
  localparam int WORD_W  = ENTRY_W + 1;

  typedef enum logic [1:0] {
    HO_IDLE  = 2'd0,
    HO_WAIT  = 2'd1,
    HO_FIRED = 2'd2
  } ho_state_t;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  rxq_pkg::rxq_entry_t wdata,
  input  logic                re,
  input  logic [AW-1:0]       raddr,
  output rxq_pkg::rxq_entry_t rdata
);
  localparam int EW = rxq_pkg::ENTRY_W;

  logic [EW-1:0] store [0:DEPTH-1];

  // Single write port, registered read port, read-first behaviour.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= rxq_pkg::rxq_entry_t'(store[raddr]);
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          ovw,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nx,
  output logic          not_empty
);
  logic [AW-1:0] wptr, rptr;
  logic          pop, grow;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
  endfunction

  always_comb begin
    pop      = pop_req && (count != '0);
    ovw      = push_req && (count == CW'(DEPTH)) && !pop;
    grow     = push_req && !ovw;
    we       = push_req;
    waddr    = ovw ? ptr_dec(wptr) : wptr;
    re       = pop;
    raddr    = rptr;
    count_nx = count + CW'(grow) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      not_empty <= 1'b0;
    end else begin
      if (grow) wptr <= ptr_inc(wptr);
      if (pop)  rptr <= ptr_inc(rptr);
      count     <= count_nx;
      not_empty <= (count_nx != '0);
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_full_overwrite_R4: assert property (@(posedge clk) disable iff (rst)
    ovw |=> (count == CW'(DEPTH)));

  assert_drain_by_read_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(not_empty) && !$past(rst)) |-> $past(pop_req));
endmodule

// File: rtl/rxq_irq_holdoff.sv
module rxq_irq_holdoff #(
  parameter int CW     = 7,
  parameter int TW     = 8,
  parameter int THRESH = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rie,
  input  logic          tick,
  input  logic [TW-1:0] tval,
  input  logic          push,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] count_nx,
  output logic          irq
);
  import rxq_pkg::*;

  ho_state_t     st, st_nx;
  logic [TW-1:0] hold, hold_nx;
  logic          rie_q, timed, ev, irq_nx;

  always_comb begin
    timed = (tval > TW'(1));
    ev    = rie && timed &&
            ((push && (count == '0)) || (!rie_q && (count != '0)));
    st_nx   = st;
    hold_nx = hold;
    if ((count_nx == '0) || !rie) begin
      st_nx = HO_IDLE;
    end else if (ev) begin
      st_nx   = HO_WAIT;
      hold_nx = tval;
    end else if ((st == HO_WAIT) && tick) begin
      hold_nx = hold - TW'(1);
      if (hold == TW'(1)) st_nx = HO_FIRED;
    end
    irq_nx = 1'b0;
    if (rie && (count_nx != '0)) begin
      if (tval == '0)         irq_nx = (count_nx >= CW'(THRESH));
      else if (tval == TW'(1)) irq_nx = 1'b1;
      else                    irq_nx = (st_nx == HO_FIRED);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= HO_IDLE;
      hold  <= '0;
      rie_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      st    <= st_nx;
      hold  <= hold_nx;
      rie_q <= rie;
      irq   <= irq_nx;
    end
  end

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    !rie |=> !irq);

  assert_immediate_mode_R6: assert property (@(posedge clk) disable iff (rst)
    ((tval == TW'(1)) && rie && (count_nx != '0)) |=> irq);

  assert_threshold_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(tval) == '0) && irq) |-> (count >= CW'(THRESH)));

  assert_timed_rise_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq) && ($past(tval) > TW'(1))) |-> $past(tick));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    ((st == HO_WAIT) && (st_nx == HO_WAIT) && !tick) |=> $stable(hold));
endmodule

// File: rtl/rxq_holdoff.sv
module rxq_holdoff #(
  parameter int DEPTH = 64,
  parameter int TW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [rxq_pkg::LINE_W-1:0] wr_line,
  input  logic [rxq_pkg::DATA_W-1:0] wr_data,
  input  logic                       wr_ovr,
  input  logic                       wr_frm,
  input  logic                       wr_par,
  input  logic                       rd_en,
  output logic [rxq_pkg::WORD_W-1:0] rd_word,
  input  logic                       rie,
  input  logic                       tim_we,
  input  logic [TW-1:0]              tim_val,
  input  logic                       tick_ms,
  output logic                       irq,
  output logic                       not_empty
);
  import rxq_pkg::*;

  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int THRESH = (DEPTH * 3) / 4;

  logic          we, re, ovw, rd_vld_q;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count, count_nx;
  logic [TW-1:0] tval_q;
  rxq_entry_t    wentry, rentry;

  always_comb begin
    wentry.ovr  = wr_ovr | ovw;
    wentry.frm  = wr_frm;
    wentry.par  = wr_par;
    wentry.line = wr_line;
    wentry.data = wr_data;
  end

  rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .push_req  (wr_en),
    .pop_req   (rd_en),
    .we        (we),
    .waddr     (waddr),
    .re        (re),
    .raddr     (raddr),
    .ovw       (ovw),
    .count     (count),
    .count_nx  (count_nx),
    .not_empty (not_empty)
  );

  rxq_mem #(.DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wentry),
    .re    (re),
    .raddr (raddr),
    .rdata (rentry)
  );

  rxq_irq_holdoff #(.CW(CW), .TW(TW), .THRESH(THRESH)) hold_i (
    .clk      (clk),
    .rst      (rst),
    .rie      (rie),
    .tick     (tick_ms),
    .tval     (tval_q),
    .push     (wr_en),
    .count    (count),
    .count_nx (count_nx),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tval_q   <= TW'(1);
      rd_vld_q <= 1'b0;
    end else begin
      if (tim_we) tval_q <= tim_val;
      if (rd_en)  rd_vld_q <= not_empty;
    end
  end

  assign rd_word = rd_vld_q ? {1'b1, rentry} : '0;

  assert_reset_state_R5: assert property (@(posedge clk)
    rst |=> ((tval_q == TW'(1)) && !not_empty && !irq && (rd_word == '0)));

  assert_empty_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !not_empty) |=> (rd_word == '0));
endmodule

// File: tb/rxq_holdoff_tb_top.sv
module rxq_holdoff_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_ovr = 1'b0, wr_frm = 1'b0, wr_par = 1'b0;
  logic [3:0]  wr_line = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0, rie = 1'b0, tim_we = 1'b0, tick_ms = 1'b0;
  logic [7:0]  tim_val = '0;
  logic [15:0] rd_word;
  logic        irq, not_empty;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R5";
  bit    armed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_holdoff dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data),
    .wr_ovr(wr_ovr), .wr_frm(wr_frm), .wr_par(wr_par), .rd_en(rd_en),
    .rd_word(rd_word), .rie(rie), .tim_we(tim_we), .tim_val(tim_val),
    .tick_ms(tick_ms), .irq(irq), .not_empty(not_empty)
  );

  // Behavioural reference model
  logic [14:0] mq[$];
  logic [15:0] m_word;
  logic        m_irq, m_prev_rie;
  int          m_tval, m_phase, m_hold;

  always @(posedge clk) begin
    int c, n;
    bit ev;
    logic [14:0] e;
    if (rst) begin
      mq.delete(); m_word = '0; m_irq = 0; m_prev_rie = 0;
      m_tval = 1; m_phase = 0; m_hold = 0;
    end else begin
      armed = 1;
      c = mq.size();
      e = {wr_ovr, wr_frm, wr_par, wr_line, wr_data};
      ev = rie && (m_tval >= 2) &&
           ((wr_en && c == 0) || (!m_prev_rie && c != 0));
      if (rd_en) m_word = (c > 0) ? {1'b1, mq[0]} : 16'h0000;
      if (rd_en && c > 0) void'(mq.pop_front());
      if (wr_en) begin
        if (c == 64 && !rd_en) mq[63] = e | 15'h4000;
        else mq.push_back(e);
      end
      n = mq.size();
      if (n == 0 || !rie) m_phase = 0;
      else if (ev) begin m_phase = 1; m_hold = m_tval; end
      else if (m_phase == 1 && tick_ms) begin
        m_hold--;
        if (m_hold == 0) m_phase = 2;
      end
      if (!rie || n == 0)   m_irq = 0;
      else if (m_tval == 0) m_irq = (n >= 48);
      else if (m_tval == 1) m_irq = 1;
      else                  m_irq = (m_phase == 2);
      if (tim_we) m_tval = tim_val;
      m_prev_rie = rie;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && armed) begin
      chk(cur_req, "model rd_word", rd_word, m_word);
      chk(cur_req, "model not_empty", {15'd0, not_empty}, {15'd0, (mq.size() != 0)});
      chk(cur_req, "model irq", {15'd0, irq}, {15'd0, m_irq});
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic push(input logic [3:0] ln, input logic [7:0] d,
                      input logic o, input logic f, input logic p);
    wr_en = 1; wr_line = ln; wr_data = d; wr_ovr = o; wr_frm = f; wr_par = p;
    cyc();
    wr_en = 0; wr_ovr = 0; wr_frm = 0; wr_par = 0;
  endtask

  task automatic pop(output logic [15:0] w);
    rd_en = 1;
    cyc();
    rd_en = 0;
    w = rd_word;
  endtask

  task automatic tick();
    tick_ms = 1; cyc(); tick_ms = 0;
  endtask

  task automatic set_time(input logic [7:0] v);
    tim_we = 1; tim_val = v; cyc(); tim_we = 0;
  endtask

  task automatic drain();
    logic [15:0] w;
    while (not_empty) pop(w);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(posedge clk);
    #2 rst = 0;

    // R5: reset state at the ports
    chk("R5", "not_empty after reset", {15'd0, not_empty}, 16'h0000);
    chk("R5", "irq after reset", {15'd0, irq}, 16'h0000);
    chk("R5", "rd_word after reset", rd_word, 16'h0000);

    // R2: empty read
    cur_req = "R2";
    pop(w); chk("R2", "empty read", w, 16'h0000);

    // R6 (reset hold-off value 1, R5) and R1 layout
    cur_req = "R6";
    rie = 1; cyc();
    push(4'd2, 8'h41, 0, 0, 0);
    chk("R6", "irq with first char", {15'd0, irq}, 16'h0001);
    chk("R3", "not_empty with first char", {15'd0, not_empty}, 16'h0001);
    push(4'd7, 8'h5A, 0, 1, 0);
    push(4'd3, 8'h00, 1, 1, 1);
    cur_req = "R1";
    pop(w); chk("R1", "word 0", w, 16'h8241);
    chk("R3", "still non-empty", {15'd0, not_empty}, 16'h0001);
    pop(w); chk("R1", "word 1 framing", w, 16'hA75A);
    pop(w); chk("R1", "word 2 all flags", w, 16'hF300);
    chk("R3", "empty after drain", {15'd0, not_empty}, 16'h0000);
    chk("R6", "irq drops on empty", {15'd0, irq}, 16'h0000);
    pop(w); chk("R2", "read past end", w, 16'h0000);

    // R11: enable low blocks the request
    cur_req = "R11";
    rie = 0; cyc();
    push(4'd1, 8'h10, 0, 0, 0);
    chk("R11", "irq with rie low", {15'd0, irq}, 16'h0000);
    rie = 1; cyc();
    chk("R10", "enable rise, immediate mode", {15'd0, irq}, 16'h0001);
    drain();

    // R8: timed mode, N = 3
    cur_req = "R8";
    set_time(8'd3);
    push(4'd0, 8'h31, 0, 0, 0);
    tick(); tick();
    chk("R8", "irq after 2 of 3 ticks", {15'd0, irq}, 16'h0000);
    tick();
    chk("R8", "irq after 3 ticks", {15'd0, irq}, 16'h0001);
    drain();
    chk("R8", "irq after drain", {15'd0, irq}, 16'h0000);

    // R9: no restart during countdown, restart after drain
    cur_req = "R9";
    push(4'd4, 8'h01, 0, 0, 0);
    tick();
    push(4'd4, 8'h02, 0, 0, 0);
    tick();
    chk("R9", "irq before 3rd tick", {15'd0, irq}, 16'h0000);
    tick();
    chk("R9", "extra char did not restart", {15'd0, irq}, 16'h0001);
    drain();
    push(4'd6, 8'h03, 0, 0, 0);
    tick(); tick();
    chk("R9", "fresh countdown not done", {15'd0, irq}, 16'h0000);
    tick();
    chk("R9", "fresh countdown done", {15'd0, irq}, 16'h0001);
    drain();

    // R10: enable rise with queued data is an event
    cur_req = "R10";
    rie = 0; cyc();
    push(4'd5, 8'h77, 0, 0, 0);
    push(4'd5, 8'h78, 0, 0, 0);
    tick();
    rie = 1; cyc();
    chk("R10", "no irq at enable rise", {15'd0, irq}, 16'h0000);
    tick(); tick();
    chk("R10", "irq after 2 ticks", {15'd0, irq}, 16'h0000);
    tick();
    chk("R10", "irq after 3 ticks", {15'd0, irq}, 16'h0001);
    drain();

    // R7: three-quarter threshold
    cur_req = "R7";
    set_time(8'd0);
    for (int i = 0; i < 47; i++) push(4'(i % 8), 8'(i), 0, 0, 0);
    chk("R7", "irq at 47 entries", {15'd0, irq}, 16'h0000);
    push(4'd1, 8'hC8, 0, 0, 0);
    chk("R7", "irq at 48 entries", {15'd0, irq}, 16'h0001);
    drain();
    chk("R7", "irq after drain", {15'd0, irq}, 16'h0000);

    // R4: full queue and overrun replacement
    cur_req = "R4";
    set_time(8'd1);
    for (int i = 0; i < 64; i++) push(4'(i % 8), 8'(i), 0, 0, 0);
    push(4'd5, 8'hAA, 0, 1, 0);
    chk("R4", "not_empty when full", {15'd0, not_empty}, 16'h0001);
    for (int i = 0; i < 64; i++) begin
      pop(w);
      if (i < 63) chk("R4", "kept entry", w, {1'b1, 3'b000, 4'(i % 8), 8'(i)});
      else        chk("R4", "overrun entry", w, 16'hE5AA);
    end
    chk("R4", "empty after 64 reads", {15'd0, not_empty}, 16'h0000);
    pop(w); chk("R2", "read after full drain", w, 16'h0000);

    repeat (2) cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule